// File: doc/BRIEF.md
# Vector byte table lookup unit

This block performs a byte-wise table lookup over a small SIMD register file. It stores 32 vector registers of 128 bits each, loaded through a single write port. A lookup takes a 64-bit word of eight byte indices, a first table register, a table length of one to four registers and an initial 64-bit result. It then produces eight result bytes, one per byte lane. The table is the concatenation of consecutive registers starting at the first table register, and it wraps from register 31 back to register 0.

A lane whose index lies outside the table is filled by a mode input. In zero-fill mode the lane becomes zero. In keep mode the lane takes the matching byte of the initial result, which is normally the destination's previous contents. A lookup is started with a one-cycle start pulse and handles one lane per clock. A one-cycle done pulse marks the result as valid. While a lookup runs, the busy output is high, and register writes and new starts are ignored.

Top module: `vtbl_unit`

## Requirements
- R1: After reset, busy, done and result are all zero.
- R2: For an in-range lane L, whose index byte is i = idx_word[8L+7:8L], compute h = (2*first_reg + i[7:3]) mod 64. Result byte L is then byte i[2:0] of 64-bit half h[0] of register h[5:1]. Half 0 is bits 63:0 and half 1 is bits 127:64. Byte k of a half is bits [8k+7:8k].
- R3: An index i is in range exactly when i < 16*tbl_len. Only the lengths 1 to 4 are used.
- R4: When keep_mode is 0, every out-of-range lane of the result is 8'h00, whatever init_word holds.
- R5: When keep_mode is 1, every out-of-range lane of the result is the byte of init_word in the same lane.
- R6: A table that runs past register 31 continues at register 0.
- R7: A start accepted while idle raises busy in the next cycle. Busy then stays high for exactly 8 cycles. When busy falls, done is high for exactly one cycle and result holds the new value. Result then stays unchanged until the next accepted lookup completes.
- R8: A register write (wr_en high) is ignored while busy is high. A write made while idle is seen by later lookups.
- R9: A start pulse while busy is high is ignored. The running lookup completes with its own operands and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register written |
| wr_data | input | 128 | Write data |
| start | input | 1 | Start a lookup (used when idle) |
| first_reg | input | 5 | First table register |
| tbl_len | input | 3 | Table length in registers, 1 to 4 |
| idx_word | input | 64 | Eight byte indices, lane L in bits 8L+7:8L |
| init_word | input | 64 | Initial result, used in keep mode |
| keep_mode | input | 1 | 1: out-of-range lanes keep init_word; 0: they become zero |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 64 | Looked-up bytes |

## Verification
Every first register from 0 to 31 is tried with every table length and both fill modes. The index words fall into three families: indices that stay inside the shortest table, indices that run past the table end, and indices spread over the full byte range. Together these separate a wrong half or byte select from a wrong range bound or a wrong fill. First registers near 31 with long tables show whether the register number wraps. Separate lookups place a write and a second start inside a running lookup. A following lookup then shows whether the table or the operands were disturbed.

// File: rtl/vtbl_unit.sv
module vtbl_unit #(
  parameter int NREGS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [4:0]   wr_idx,
  input  logic [127:0] wr_data,
  input  logic         start,
  input  logic [4:0]   first_reg,
  input  logic [2:0]   tbl_len,
  input  logic [63:0]  idx_word,
  input  logic [63:0]  init_word,
  input  logic         keep_mode,
  output logic         busy,
  output logic         done,
  output logic [63:0]  result
);
  localparam int RW = $clog2(NREGS);
  localparam int HW = RW + 1;

  logic [127:0]  regs [NREGS];
  logic [63:0]   idx_q, acc, nxt;
  logic [RW-1:0] base_q;
  logic [2:0]    len_q, lane;

  wire [7:0]    cur   = idx_q[{lane, 3'b000} +: 8];
  wire          in_rng = {1'b0, cur} < {2'b00, len_q, 4'b0000};
  wire [HW-1:0] half  = {base_q, 1'b0} + HW'(cur[7:3]);
  wire [127:0]  row   = regs[half[HW-1:1]];
  wire [7:0]    pick  = row[{half[0], cur[2:0], 3'b000} +: 8];

  always_comb begin
    nxt = acc;
    if (in_rng) nxt[{lane, 3'b000} +: 8] = pick;
  end

  always_ff @(posedge clk)
    if (wr_en && !busy) regs[wr_idx[RW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      acc    <= '0;
      idx_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      lane   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx_q  <= idx_word;
          base_q <= first_reg[RW-1:0];
          len_q  <= tbl_len;
          lane   <= '0;
          acc    <= keep_mode ? init_word : '0;
        end
      end else begin
        acc  <= nxt;
        lane <= lane + 3'd1;
        if (lane == 3'd7) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= nxt;
        end
      end
    end
  end
endmodule

module vtbl_unit_chk #(
  parameter int LANES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [63:0] result
);
  localparam int CW = $clog2(LANES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk)
    if (!rst_n) cnt <= '0;
    else cnt <= busy ? cnt + 1'b1 : '0;

  // R7
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cnt == CW'(LANES)));
  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(LANES));
  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind vtbl_unit vtbl_unit_chk #(.LANES(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result)
);

// File: tb/vtbl_unit_tb.sv
module vtbl_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, keep_mode = 0;
  logic [4:0] wr_idx = 0, first_reg = 0;
  logic [127:0] wr_data = 0;
  logic [2:0] tbl_len = 1;
  logic [63:0] idx_word = 0, init_word = 0;
  logic busy, done;
  logic [63:0] result;

  logic [127:0] model [32];
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtbl_unit u_dut (.*);

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_res(int b, int len, logic km,
                                          logic [63:0] init, logic [63:0] idx);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) begin
      int i = int'(idx[l*8 +: 8]);
      if (i < 16*len) begin
        int h = (2*b + i/8) % 64;
        logic [127:0] m = model[h/2];
        r[l*8 +: 8] = m[(h%2)*64 + (i%8)*8 +: 8];
      end else
        r[l*8 +: 8] = km ? init[l*8 +: 8] : 8'h00;
    end
    return r;
  endfunction

  task automatic write_reg(int r, logic [127:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(r); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model[r] = d;
  endtask

  task automatic lookup(string tag, int b, int len, logic km,
                        logic [63:0] init, logic [63:0] idx,
                        bit disturb);
    logic [63:0] exp;
    exp = ref_res(b, len, km, init, idx);
    @(negedge clk);
    start = 1; first_reg = 5'(b); tbl_len = 3'(len);
    keep_mode = km; init_word = init; idx_word = idx;
    @(negedge clk);
    start = 0;
    check("R7 busy", {63'd0, busy}, 64'd1);
    for (int n = 2; n <= 8; n++) begin
      if (disturb && n == 3) begin
        wr_en = 1; wr_idx = 5'(b); wr_data = ~model[b];
        start = 1; idx_word = ~idx; keep_mode = ~km;
      end
      @(negedge clk);
      wr_en = 0; start = 0;
      if (busy !== 1'b1 || done !== 1'b0) begin
        check("R7 busy window", {62'd0, busy, done}, 64'd2);
      end
    end
    @(negedge clk);
    check("R7 done", {62'd0, busy, done}, 64'd1);
    check(tag, result, exp);
    @(negedge clk);
    check("R7 hold", {63'd0, done}, 64'd0);
    check("R7 result hold", result, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {result[61:0], busy, done}, 64'd0);
    rst_n = 1;
    for (int r = 0; r < 32; r++) begin
      logic [127:0] d;
      for (int k = 0; k < 16; k++) d[k*8 +: 8] = 8'((r*16 + k) ^ 8'h5A);
      write_reg(r, d);
    end
    for (int b = 0; b < 32; b++)
      for (int len = 1; len <= 4; len++)
        for (int km = 0; km < 2; km++) begin
          logic [63:0] i_in, i_over, i_wide, init;
          init = {8{8'(b*7 + len)}} ^ 64'hF0E1D2C3B4A59687;
          for (int l = 0; l < 8; l++) begin
            i_in[l*8 +: 8]   = 8'((l*5 + b) % 16);
            i_over[l*8 +: 8] = 8'(16*len - 4 + l);
            i_wide[l*8 +: 8] = 8'(l*37 + b*11 + len);
          end
          lookup("R2 in-range", b, len, km[0], init, i_in, 0);
          lookup(km ? "R5 keep" : "R4 zero", b, len, km[0], init, i_over, 0);
          lookup(b >= 30 ? "R6 wrap" : "R3 range", b, len, km[0], init, i_wide, 0);
        end
    lookup("R6 wrap 31", 31, 4, 0, 0, 64'h3F30_2F20_1F10_0F00, 0);
    lookup("R8 R9 disturbed", 7, 2, 1, 64'h1122334455667788,
           64'h1F1E_1110_0908_0100, 1);
    lookup("R8 write ignored", 7, 1, 0, 0, 64'h0F0E_0D0C_0302_0100, 0);
    write_reg(9, 128'h00112233445566778899AABBCCDDEEFF);
    lookup("R8 write taken", 9, 1, 0, 0, 64'h0F0E_0D0C_0302_0100, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule